// File: doc/BRIEF.md
# Command-Paged Register Window

This block is the address decoder and storage for a small register window. In it one write offset, the paging slot, is normally dead. An auxiliary command register accepts opcodes. Four of those opcodes pick which of four write-only registers the paging slot reaches. Another opcode withdraws the selection. While a selection is active, two status inputs become readable at offsets that otherwise read zero: a serial-poll status byte and an interrupt status byte.

The window has two register layouts. In the primary layout there is no paging. The alternate layout has the paging slot. A swap input, honoured only in the alternate layout, moves three registers to the offsets the primary layout uses: the data-in register, the command/data-out register and the auxiliary command register. The layout is taken from a pin at reset and can later be changed by command. Reads are combinational from the address. Writes take effect at the clock edge on which `wr_en_i` is high.

Top module: `pgw_window`

## Requirements
- R1: During and after reset, no page is selected, `cdo_o` and every byte of `pg_regs_o` are zero, and `alt_mode_o` equals the inverse of `mode_pin_i` (pin high gives the primary layout, `alt_mode_o`=0).
- R2: In the alternate layout with no page selected, a write to offset 4 changes no byte of `pg_regs_o`. Reads of offsets 4 and 6 return 0.
- R3: An auxiliary write of 0x50+k (k=0..3) selects page k. Every later write to offset 4 lands in byte k of `pg_regs_o` (bits 8k+7..8k). The selection persists over any number of such writes.
- R4: A page-in command issued while another page is active replaces the selection directly. No clear is needed.
- R5: While any page is selected in the alternate layout, offset 4 reads `sp_stat_i` and offset 6 reads `irq_stat_i`.
- R6: An auxiliary write of 0x5F deselects every page. After it, writes to offset 4 are ignored and offsets 4 and 6 read 0.
- R7: In the alternate layout with `swap_i` low, `din_i` is read and `cdo_o` is written at offset 7, the auxiliary command register is at offset 3, and `adr_stat_i` is read at offset 0.
- R8: In the alternate layout with `swap_i` high, `din_i`/`cdo_o` move to offset 0, the auxiliary register moves to offset 5, and `adr_stat_i` moves to offset 7. Auxiliary writes to offset 3 are then ignored.
- R9: In the primary layout, `din_i`/`cdo_o` are at offset 0 and the auxiliary register is at offset 5. Writes to offset 4 are ignored and offsets 4 and 6 read 0, even when a page is selected. `swap_i` has no effect.
- R10: An auxiliary write of 0x60 selects the primary layout and 0x61 selects the alternate layout, shown on `alt_mode_o` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_pin_i | input | 1 | Layout sampled at reset: 1 primary, 0 alternate |
| swap_i | input | 1 | Relocates data and auxiliary registers in the alternate layout |
| addr_i | input | 3 | Register offset |
| wr_en_i | input | 1 | Write strobe, one write per high cycle |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Combinational read data for `addr_i` |
| din_i | input | DW | Data-in value shown by the data-in register |
| adr_stat_i | input | DW | Address status value |
| sp_stat_i | input | DW | Serial-poll status, visible while paged |
| irq_stat_i | input | DW | Interrupt status, visible while paged |
| cdo_o | output | DW | Command/data-out register |
| pg_regs_o | output | N_PAGES*DW | The paged write-only registers, page k in byte k |
| alt_mode_o | output | 1 | 1 when the alternate layout is active |

## Verification
The assertions assume `wr_en_i`, `addr_i` and `wdata_i` are steady around each clock edge. They also assume `mode_pin_i` is meaningful only while reset is asserted. The stimulus changes every input at the falling edge and toggles the mode pin only with reset held. It keeps `swap_i` steady for the length of each scenario, so that a paging or auxiliary write is never decoded under a layout different from the one the expected value is computed for.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {WR_NONE, WR_CDO, WR_AUX, WR_PAGE} wr_tgt_e;
  typedef enum logic [2:0] {RD_ZERO, RD_DIN, RD_ADR, RD_SPS, RD_IRQ} rd_src_e;

  // primary layout
  localparam logic [ADDR_W-1:0] OFS_DATA_P = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_AUX_P  = 3'd5;
  // alternate layout, unswapped
  localparam logic [ADDR_W-1:0] OFS_DATA_A = 3'd7;
  localparam logic [ADDR_W-1:0] OFS_AUX_A  = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_ADR_A  = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_PAGE   = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_IRQ    = 3'd6;

  localparam logic [7:0] CMD_PAGE_BASE = 8'h50;
  localparam logic [7:0] CMD_PAGE_CLR  = 8'h5F;
  localparam logic [7:0] CMD_MODE_PRI  = 8'h60;
  localparam logic [7:0] CMD_MODE_ALT  = 8'h61;
endpackage

// File: rtl/pgw_decode.sv
module pgw_decode
  import pgw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              alt_i,
  input  logic              swap_i,
  input  logic              pg_act_i,
  output wr_tgt_e           wr_tgt_o,
  output rd_src_e           rd_src_o
);
  logic [ADDR_W-1:0] ofs_data, ofs_aux, ofs_adr;

  // swap moves data/aux onto primary offsets; status takes the freed data slot
  assign ofs_data = swap_i ? OFS_DATA_P : OFS_DATA_A;
  assign ofs_aux  = swap_i ? OFS_AUX_P  : OFS_AUX_A;
  assign ofs_adr  = swap_i ? OFS_DATA_A : OFS_ADR_A;

  always_comb begin
    wr_tgt_o = WR_NONE;
    rd_src_o = RD_ZERO;
    if (!alt_i) begin
      if (addr_i == OFS_DATA_P) begin
        wr_tgt_o = WR_CDO;
        rd_src_o = RD_DIN;
      end else if (addr_i == OFS_AUX_P) begin
        wr_tgt_o = WR_AUX;
      end
    end else begin
      if (addr_i == ofs_data) begin
        wr_tgt_o = WR_CDO;
        rd_src_o = RD_DIN;
      end else if (addr_i == ofs_aux) begin
        wr_tgt_o = WR_AUX;
      end else if (addr_i == ofs_adr) begin
        rd_src_o = RD_ADR;
      end else if (addr_i == OFS_PAGE && pg_act_i) begin
        wr_tgt_o = WR_PAGE;
        rd_src_o = RD_SPS;
      end else if (addr_i == OFS_IRQ && pg_act_i) begin
        rd_src_o = RD_IRQ;
      end
    end
  end

  // R5
  paged_rd_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pg_act_i |-> (rd_src_o != RD_SPS && rd_src_o != RD_IRQ && wr_tgt_o != WR_PAGE));
  // R9
  primary_no_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alt_i && addr_i == OFS_PAGE) |-> (wr_tgt_o == WR_NONE && rd_src_o == RD_ZERO));
endmodule

// File: rtl/pgw_page_ctl.sv
module pgw_page_ctl
  import pgw_pkg::*;
#(
  parameter int DW      = 8,
  parameter int N_PAGES = 4,
  localparam int PSEL_W = (N_PAGES > 1) ? $clog2(N_PAGES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_pin_i,
  input  logic              aux_we_i,
  input  logic [DW-1:0]     aux_data_i,
  output logic              pg_act_o,
  output logic [PSEL_W-1:0] pg_sel_o,
  output logic              alt_o
);
  logic is_page, is_clr;
  logic [DW-1:0] pg_ofs;

  assign pg_ofs  = aux_data_i - DW'(CMD_PAGE_BASE);
  assign is_page = (aux_data_i >= DW'(CMD_PAGE_BASE)) && (pg_ofs < DW'(N_PAGES));
  assign is_clr  = aux_data_i == DW'(CMD_PAGE_CLR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pg_act_o <= 1'b0;
      pg_sel_o <= '0;
      alt_o    <= ~mode_pin_i;
    end else if (aux_we_i) begin
      if (is_page) begin
        pg_act_o <= 1'b1;
        pg_sel_o <= pg_ofs[PSEL_W-1:0];
      end else if (is_clr) begin
        pg_act_o <= 1'b0;
      end else if (aux_data_i == DW'(CMD_MODE_PRI)) begin
        alt_o <= 1'b0;
      end else if (aux_data_i == DW'(CMD_MODE_ALT)) begin
        alt_o <= 1'b1;
      end
    end
  end

  // R3 R4
  page_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux_we_i && aux_data_i >= DW'(CMD_PAGE_BASE) && aux_data_i < DW'(CMD_PAGE_BASE) + DW'(N_PAGES))
    |=> (pg_act_o && DW'(pg_sel_o) == $past(aux_data_i) - DW'(CMD_PAGE_BASE)));
  // R6
  page_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux_we_i && aux_data_i == DW'(CMD_PAGE_CLR)) |=> !pg_act_o);
  // R10
  mode_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux_we_i && (aux_data_i == DW'(CMD_MODE_PRI) || aux_data_i == DW'(CMD_MODE_ALT)))
    |=> (alt_o == $past(aux_data_i[0])));
endmodule

// File: rtl/pgw_wr_regs.sv
module pgw_wr_regs #(
  parameter int DW      = 8,
  parameter int N_PAGES = 4,
  localparam int PSEL_W = (N_PAGES > 1) ? $clog2(N_PAGES) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cdo_we_i,
  input  logic                  page_we_i,
  input  logic [PSEL_W-1:0]     pg_sel_i,
  input  logic [DW-1:0]         wdata_i,
  output logic [DW-1:0]         cdo_o,
  output logic [N_PAGES*DW-1:0] pg_regs_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cdo_o <= '0;
    else if (cdo_we_i) cdo_o <= wdata_i;
  end

  for (genvar k = 0; k < N_PAGES; k++) begin : g_page
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        pg_regs_o[k*DW +: DW] <= '0;
      else if (page_we_i && pg_sel_i == PSEL_W'(k))
        pg_regs_o[k*DW +: DW] <= wdata_i;
    end
  end

  // R2 R6 R9
  page_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !page_we_i |=> $stable(pg_regs_o));
  // R3
  page_one_hot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_we_i |=> ($countones($past(pg_regs_o) ^ pg_regs_o) <= DW));
endmodule

// File: rtl/pgw_window.sv
module pgw_window
  import pgw_pkg::*;
#(
  parameter int DW      = 8,
  parameter int N_PAGES = 4,
  localparam int PSEL_W = (N_PAGES > 1) ? $clog2(N_PAGES) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  mode_pin_i,
  input  logic                  swap_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  wr_en_i,
  input  logic [DW-1:0]         wdata_i,
  output logic [DW-1:0]         rdata_o,
  input  logic [DW-1:0]         din_i,
  input  logic [DW-1:0]         adr_stat_i,
  input  logic [DW-1:0]         sp_stat_i,
  input  logic [DW-1:0]         irq_stat_i,
  output logic [DW-1:0]         cdo_o,
  output logic [N_PAGES*DW-1:0] pg_regs_o,
  output logic                  alt_mode_o
);
  wr_tgt_e           wr_tgt;
  rd_src_e           rd_src;
  logic              pg_act;
  logic [PSEL_W-1:0] pg_sel;

  pgw_decode u_dec (
    .clk_i, .rst_ni, .addr_i,
    .alt_i(alt_mode_o), .swap_i, .pg_act_i(pg_act),
    .wr_tgt_o(wr_tgt), .rd_src_o(rd_src)
  );

  pgw_page_ctl #(.DW(DW), .N_PAGES(N_PAGES)) u_ctl (
    .clk_i, .rst_ni, .mode_pin_i,
    .aux_we_i(wr_en_i && wr_tgt == WR_AUX), .aux_data_i(wdata_i),
    .pg_act_o(pg_act), .pg_sel_o(pg_sel), .alt_o(alt_mode_o)
  );

  pgw_wr_regs #(.DW(DW), .N_PAGES(N_PAGES)) u_regs (
    .clk_i, .rst_ni,
    .cdo_we_i(wr_en_i && wr_tgt == WR_CDO),
    .page_we_i(wr_en_i && wr_tgt == WR_PAGE),
    .pg_sel_i(pg_sel), .wdata_i,
    .cdo_o, .pg_regs_o
  );

  always_comb begin
    unique case (rd_src)
      RD_DIN:  rdata_o = din_i;
      RD_ADR:  rdata_o = adr_stat_i;
      RD_SPS:  rdata_o = sp_stat_i;
      RD_IRQ:  rdata_o = irq_stat_i;
      default: rdata_o = '0;
    endcase
  end

  // R9
  primary_page_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alt_mode_o && wr_en_i && addr_i == OFS_PAGE) |=> $stable(pg_regs_o));
  // R7 R8
  alt_cdo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alt_mode_o && wr_en_i && addr_i == (swap_i ? OFS_DATA_P : OFS_DATA_A))
    |=> cdo_o == $past(wdata_i));
endmodule

// File: tb/pgw_window_test.sv
`timescale 1ns/100ps
module pgw_window_test;
  localparam int DW = 8;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_pin = 1'b0;
  logic swap = 1'b0;
  logic [2:0] addr = '0;
  logic we = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata, cdo;
  logic [NP*DW-1:0] pgr;
  logic alt;
  logic [DW-1:0] din = 8'hD1, adr = 8'hA5, sps = 8'h5C, irq = 8'h9E;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pgw_window #(.DW(DW), .N_PAGES(NP)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_pin_i(mode_pin), .swap_i(swap),
    .addr_i(addr), .wr_en_i(we), .wdata_i(wdata), .rdata_o(rdata),
    .din_i(din), .adr_stat_i(adr), .sp_stat_i(sps), .irq_stat_i(irq),
    .cdo_o(cdo), .pg_regs_o(pgr), .alt_mode_o(alt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic do_reset(input logic pin);
    @(negedge clk); rst_n = 1'b0; mode_pin = pin; swap = 1'b0; we = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // R1
  task automatic t_reset();
    do_reset(1'b1);
    chk("R1 alt_mode pin high", alt, 0);
    chk("R1 cdo", cdo, 0);
    chk("R1 pages", pgr, 0);
    do_reset(1'b0);
    chk("R1 alt_mode pin low", alt, 1);
  endtask

  // R2
  task automatic t_page_off();
    logic [DW-1:0] v;
    wr(3'd4, 8'h77);
    chk("R2 write ignored", pgr, 0);
    rd(3'd4, v); chk("R2 read 4", v, 0);
    rd(3'd6, v); chk("R2 read 6", v, 0);
  endtask

  // R3 R5
  task automatic t_page_select();
    logic [DW-1:0] v;
    wr(3'd3, 8'h52);
    wr(3'd4, 8'h11);
    chk("R3 page 2 first", pgr, 32'h0011_0000);
    wr(3'd4, 8'h22);
    chk("R3 page 2 persists", pgr, 32'h0022_0000);
    rd(3'd4, v); chk("R5 sp status", v, sps);
    rd(3'd6, v); chk("R5 irq status", v, irq);
  endtask

  // R4
  task automatic t_page_replace();
    wr(3'd3, 8'h50);
    wr(3'd4, 8'h33);
    chk("R4 page 0 replaces", pgr, 32'h0022_0033);
    wr(3'd3, 8'h53);
    wr(3'd4, 8'h44);
    chk("R4 page 3 replaces", pgr, 32'h4422_0033);
    wr(3'd3, 8'h51);
    wr(3'd4, 8'h55);
    chk("R4 page 1 replaces", pgr, 32'h4422_5533);
  endtask

  // R6
  task automatic t_page_clear();
    logic [DW-1:0] v;
    wr(3'd3, 8'h5F);
    wr(3'd4, 8'hEE);
    chk("R6 write after clear", pgr, 32'h4422_5533);
    rd(3'd4, v); chk("R6 read 4", v, 0);
    rd(3'd6, v); chk("R6 read 6", v, 0);
  endtask

  // R7
  task automatic t_alt_map();
    logic [DW-1:0] v;
    swap = 1'b0;
    rd(3'd7, v); chk("R7 din at 7", v, din);
    rd(3'd0, v); chk("R7 adr at 0", v, adr);
    wr(3'd7, 8'hC7);
    chk("R7 cdo at 7", cdo, 8'hC7);
    wr(3'd0, 8'h01);
    chk("R7 write 0 no cdo", cdo, 8'hC7);
  endtask

  // R8
  task automatic t_swap_map();
    logic [DW-1:0] v;
    @(negedge clk); swap = 1'b1;
    rd(3'd0, v); chk("R8 din at 0", v, din);
    rd(3'd7, v); chk("R8 adr at 7", v, adr);
    wr(3'd0, 8'hC0);
    chk("R8 cdo at 0", cdo, 8'hC0);
    wr(3'd3, 8'h50);
    rd(3'd4, v); chk("R8 aux at 3 ignored", v, 0);
    wr(3'd5, 8'h50);
    rd(3'd4, v); chk("R8 aux at 5", v, sps);
    wr(3'd4, 8'h66);
    chk("R8 page 0 via swapped aux", pgr, 32'h4422_5566);
    @(negedge clk); swap = 1'b0;
  endtask

  // R9 R10 (page 0 remains selected here)
  task automatic t_primary_map();
    logic [DW-1:0] v;
    wr(3'd3, 8'h60);
    chk("R10 primary cmd", alt, 0);
    wr(3'd4, 8'h99);
    chk("R9 page slot ignored", pgr, 32'h4422_5566);
    rd(3'd4, v); chk("R9 read 4", v, 0);
    rd(3'd6, v); chk("R9 read 6", v, 0);
    rd(3'd0, v); chk("R9 din at 0", v, din);
    wr(3'd0, 8'hB0);
    chk("R9 cdo at 0", cdo, 8'hB0);
    @(negedge clk); swap = 1'b1;
    wr(3'd7, 8'hB7);
    chk("R9 swap ignored", cdo, 8'hB0);
    @(negedge clk); swap = 1'b0;
    wr(3'd5, 8'h61);
    chk("R10 alternate cmd", alt, 1);
    rd(3'd4, v); chk("R10 page kept in alternate", v, sps);
  endtask

  initial begin
    t_reset();
    t_page_off();
    t_page_select();
    t_page_replace();
    t_page_clear();
    t_alt_map();
    t_swap_map();
    t_primary_map();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule